// File: doc/BRIEF.md
# Counter Timebase Select and Mode Control

This block drives a free-running up-counter from one of several timebases and holds the small mode register that steers it. A 3-bit source code picks among two fixed divisions of the system clock, the system clock itself, a timer-0 overflow pulse, falling edges on an external count pin, and divide-by-8 of two asynchronous clocks. The two asynchronous clocks are an external clock and a real-time clock. Whatever the source, the block turns it into a single-cycle count-enable tick in the system clock domain. The counter advances by one on each tick.

The mode register also holds four control bits. An idle-suspend bit freezes counting while the CPU reports idle. A watchdog-enable bit can be pinned on by a sticky lock bit. An overflow interrupt enable gates the interrupt request. The request is raised from an overflow flag, which the counter sets when it wraps. A write strobe with an 8-bit data word replaces the register contents in one cycle. The current contents are always visible on `mode_o`.

Top module: `ctb_timebase`

## Requirements
- R1: Source code 0 gives exactly one tick per 12 system clocks, and code 1 gives exactly one per 4. In any window of 48 (or 16) consecutive cycles the counter advances by 4.
- R2: Source code 4 gives a tick on every system clock cycle.
- R3: Source code 2 gives one tick for each single-cycle high pulse on `tmr0_ovf_i`.
- R4: Source code 3 gives one tick for each high-to-low transition on `cnt_pin_i`, seen after a two-flop synchroniser. Low-to-high transitions give none. Pulses of 4 or more cycles per level are supported.
- R5: Source codes 5 and 6 give exactly one tick per 8 rising edges of `ext_clk_i` and `rtc_clk_i` respectively. The divided clock is carried into the system domain by a toggle synchroniser.
- R6: Source code 7 gives no ticks, whatever the other inputs do.
- R7: While the idle-suspend bit is 1 and `idle_i` is high, no ticks occur. With the bit at 0, `idle_i` has no effect.
- R8: Register layout: bit 0 is idle-suspend, bit 1 is watchdog-enable, bit 2 is watchdog-lock, bits 5:3 are the source code and bit 6 is overflow interrupt enable. Bit 7 always reads 0. After reset `mode_o` is 8'h02.
- R9: Once the lock bit is 1, it stays 1 until reset. While it is 1, a write cannot clear watchdog-enable. Without the lock, watchdog-enable takes the written value.
- R10: On each tick the counter adds one. A tick at all-ones wraps it to zero and sets `ovf_o`. `ovf_o` stays set until `ovf_clr_i` is pulsed. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R11: `irq_o` is high exactly when the overflow flag is set and the interrupt enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | CPU idle indicator |
| tmr0_ovf_i | input | 1 | Timer-0 overflow pulse, system domain |
| cnt_pin_i | input | 1 | Asynchronous external count pin |
| ext_clk_i | input | 1 | Asynchronous external clock |
| rtc_clk_i | input | 1 | Asynchronous real-time clock |
| wr_en_i | input | 1 | Mode register write strobe |
| wr_data_i | input | 8 | Mode register write data |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| mode_o | output | 8 | Current mode register contents |
| tick_o | output | 1 | Count-enable tick |
| cnt_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with `CNT_W` set to 8 and leaves the divisors and synchroniser depth at their defaults. The narrower counter puts the wrap within a few hundred cycles. That lets one run check the flag set on wrap, its hold, its clear and the interrupt gating, next to the per-source tick counts. The asynchronous clocks are run for whole multiples of eight edges from a stopped state. This gives each source an exact expected count, regardless of where the divider phase stood.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  typedef enum logic [2:0] {
    SRC_DIV_A    = 3'd0,
    SRC_DIV_B    = 3'd1,
    SRC_TMR0     = 3'd2,
    SRC_PIN_FALL = 3'd3,
    SRC_SYSCLK   = 3'd4,
    SRC_EXT_DIV  = 3'd5,
    SRC_RTC_DIV  = 3'd6,
    SRC_NONE     = 3'd7
  } src_sel_e;

  typedef struct packed {
    logic      ovf_ie;
    src_sel_e  sel;
    logic      wd_lock;
    logic      wd_en;
    logic      idle_susp;
  } mode_t;

  localparam mode_t MODE_RST = '{ovf_ie: 1'b0, sel: SRC_DIV_A, wd_lock: 1'b0,
                                 wd_en: 1'b1, idle_susp: 1'b0};
endpackage

// File: rtl/ctb_presc.sv
module ctb_presc #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pulse_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_o = (cnt_q == LAST);
endmodule

// File: rtl/ctb_fall_det.sv
module ctb_fall_det #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;

  // chain and history reset high so an idle-high pin gives no edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin_i};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC-1];
endmodule

// File: rtl/ctb_async_div.sv
module ctb_async_div #(
  parameter int unsigned DIV  = 8,
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic aclk_i,
  output logic pulse_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0]   div_q;
  logic            tgl_q;
  logic [SYNC-1:0] sync_q;
  logic            prev_q;

  // source domain: flip once per DIV edges
  always_ff @(posedge aclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      tgl_q <= 1'b0;
    end else if (div_q == LAST) begin
      div_q <= '0;
      tgl_q <= ~tgl_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], tgl_q};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign pulse_o = prev_q ^ sync_q[SYNC-1];
endmodule

// File: rtl/ctb_mode_reg.sv
module ctb_mode_reg
  import ctb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [6:0] wr_data_i,
  output mode_t      mode_o
);
  mode_t wr_m, mode_q;

  assign wr_m = mode_t'(wr_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
    end else if (wr_en_i) begin
      mode_q.idle_susp <= wr_m.idle_susp;
      mode_q.sel       <= wr_m.sel;
      mode_q.ovf_ie    <= wr_m.ovf_ie;
      mode_q.wd_lock   <= mode_q.wd_lock | wr_m.wd_lock;
      mode_q.wd_en     <= mode_q.wd_lock ? (mode_q.wd_en | wr_m.wd_en) : wr_m.wd_en;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/ctb_timebase.sv
module ctb_timebase
  import ctb_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DIV_A    = 12,
  parameter int unsigned DIV_B    = 4,
  parameter int unsigned ASYNC_DV = 8,
  parameter int unsigned SYNC     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             tmr0_ovf_i,
  input  logic             cnt_pin_i,
  input  logic             ext_clk_i,
  input  logic             rtc_clk_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic             ovf_clr_i,
  output logic [7:0]       mode_o,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             irq_o
);
  localparam int unsigned N_PRE   = 2;
  localparam int unsigned N_ASYNC = 2;
  localparam int unsigned PRE_DIV [N_PRE] = '{DIV_A, DIV_B};

  mode_t            mode;
  logic [N_PRE-1:0]   pre_p;
  logic [N_ASYNC-1:0] async_p;
  logic [N_ASYNC-1:0] aclk;
  logic             fall_p;
  logic             raw_tick;
  logic             suspend;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             unused_wd7;

  assign unused_wd7 = wr_data_i[7];

  ctb_mode_reg u_mode (
    .clk_i, .rst_ni, .wr_en_i,
    .wr_data_i (wr_data_i[6:0]),
    .mode_o    (mode)
  );

  for (genvar i = 0; i < N_PRE; i++) begin : g_pre
    ctb_presc #(.DIV(PRE_DIV[i])) u_presc (
      .clk_i, .rst_ni, .pulse_o(pre_p[i])
    );
  end

  assign aclk = {rtc_clk_i, ext_clk_i};

  for (genvar i = 0; i < N_ASYNC; i++) begin : g_async
    ctb_async_div #(.DIV(ASYNC_DV), .SYNC(SYNC)) u_adiv (
      .clk_i, .rst_ni, .aclk_i(aclk[i]), .pulse_o(async_p[i])
    );
  end

  ctb_fall_det #(.SYNC(SYNC)) u_fall (
    .clk_i, .rst_ni, .pin_i(cnt_pin_i), .fall_o(fall_p)
  );

  always_comb begin
    unique case (mode.sel)
      SRC_DIV_A:    raw_tick = pre_p[0];
      SRC_DIV_B:    raw_tick = pre_p[1];
      SRC_TMR0:     raw_tick = tmr0_ovf_i;
      SRC_PIN_FALL: raw_tick = fall_p;
      SRC_SYSCLK:   raw_tick = 1'b1;
      SRC_EXT_DIV:  raw_tick = async_p[0];
      SRC_RTC_DIV:  raw_tick = async_p[1];
      default:      raw_tick = 1'b0;
    endcase
  end

  assign suspend = mode.idle_susp & idle_i;
  assign tick_o  = raw_tick & ~suspend;
  assign wrap    = tick_o & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= cnt_q + 1'b1;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign mode_o = {1'b0, mode};
  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
  assign irq_o  = ovf_q & mode.ovf_ie;
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             idle_i,
  input logic             ovf_clr_i,
  input logic [7:0]       mode_o,
  input logic             tick_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             ovf_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_no_tick_reserved_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[5:3] == 3'd7) |-> !tick_o);

  p_idle_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[0] && idle_i) |-> !tick_o);

  p_sys_every_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[5:3] == 3'd4 && !(mode_o[0] && idle_i)) |-> tick_o);

  p_bit7_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[7]);

  p_lock_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[2] |=> mode_o[2]);

  p_wd_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[2] && mode_o[1]) |=> mode_o[1]);

  p_cnt_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_o == $past(cnt_o) + ONE);

  p_cnt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(cnt_o));

  p_ovf_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (&cnt_o)) |=> ovf_o);

  p_ovf_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  p_irq_needs_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_o && mode_o[6]));
endmodule

bind ctb_timebase ctb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .idle_i    (idle_i),
  .ovf_clr_i (ovf_clr_i),
  .mode_o    (mode_o),
  .tick_o    (tick_o),
  .cnt_o     (cnt_o),
  .ovf_o     (ovf_o),
  .irq_o     (irq_o)
);

// File: tb/sim_ctb_timebase.sv
module sim_ctb_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int CMASK      = (1 << CNT_W) - 1;

  localparam int K_DELTA = 0;
  localparam int K_MODE  = 1;
  localparam int K_OVF   = 2;
  localparam int K_IRQ   = 3;
  localparam int K_CNT   = 4;

  typedef struct {
    string tag;
    int    kind;
    int    base;
    int    exp;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             idle = 1'b0;
  logic             tmr0 = 1'b0;
  logic             pin = 1'b1;
  logic             ext_clk = 1'b0;
  logic             rtc_clk = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_data = '0;
  logic             ovf_clr = 1'b0;
  logic [7:0]       mode;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             irq;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctb_timebase #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .idle_i(idle), .tmr0_ovf_i(tmr0),
    .cnt_pin_i(pin), .ext_clk_i(ext_clk), .rtc_clk_i(rtc_clk),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .ovf_clr_i(ovf_clr),
    .mode_o(mode), .tick_o(tick), .cnt_o(cnt), .ovf_o(ovf), .irq_o(irq)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      int    act;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      case (it.kind)
        K_DELTA: act = (int'(cnt) - it.base) & CMASK;
        K_MODE:  act = int'(mode);
        K_OVF:   act = int'(ovf);
        K_IRQ:   act = int'(irq);
        default: act = int'(cnt);
      endcase
      n_checks++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(input string tag, input int kind, input int base, input int exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.base = base; it.exp = exp;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  function automatic logic [7:0] mk(input bit susp, input bit wd, input bit lk,
                                    input int sel, input bit ie);
    return {1'b0, ie, 3'(sel), lk, wd, susp};
  endfunction

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_ext(input int n);
    repeat (n) begin #13 ext_clk = 1'b1; #13 ext_clk = 1'b0; end
  endtask

  task automatic run_rtc(input int n);
    repeat (n) begin #20 rtc_clk = 1'b1; #20 rtc_clk = 1'b0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_item("R8 reset mode", K_MODE, 0, 8'h02);
    expect_item("R10 reset count", K_CNT, 0, 0);
    expect_item("R10 reset ovf", K_OVF, 0, 0);

    // R1 divide-by-12
    wr(mk(0, 1, 0, 0, 0));
    c0 = int'(cnt); cycles(48);
    expect_item("R1 div12 ticks in 48", K_DELTA, c0, 4);
    // R1 divide-by-4
    wr(mk(0, 1, 0, 1, 0));
    c0 = int'(cnt); cycles(16);
    expect_item("R1 div4 ticks in 16", K_DELTA, c0, 4);
    // R2 system clock
    wr(mk(0, 1, 0, 4, 0));
    c0 = int'(cnt); cycles(20);
    expect_item("R2 sysclk ticks in 20", K_DELTA, c0, 20);

    // R7 idle suspends with bit set
    @(negedge clk); wr_en = 1'b1; wr_data = mk(1, 1, 0, 4, 0); idle = 1'b1;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    c0 = int'(cnt); cycles(20);
    expect_item("R7 idle suspended", K_DELTA, c0, 0);
    wr(mk(0, 1, 0, 4, 0));
    c0 = int'(cnt); cycles(20);
    expect_item("R7 idle ignored when bit clear", K_DELTA, c0, 20);
    idle = 1'b0;

    // R3 timer-0 pulses
    wr(mk(0, 1, 0, 2, 0));
    c0 = int'(cnt);
    for (int i = 0; i < 5; i++) begin
      tmr0 = 1'b1; @(negedge clk); tmr0 = 1'b0; cycles(2);
    end
    cycles(2);
    expect_item("R3 timer0 pulses", K_DELTA, c0, 5);

    // R4 pin falling edges only
    wr(mk(0, 1, 0, 3, 0));
    c0 = int'(cnt);
    for (int i = 0; i < 3; i++) begin
      pin = 1'b0; cycles(4); pin = 1'b1; cycles(4);
    end
    cycles(6);
    expect_item("R4 pin falls", K_DELTA, c0, 3);

    // R5 external clock divide-by-8
    wr(mk(0, 1, 0, 5, 0));
    c0 = int'(cnt);
    run_ext(80);
    cycles(8);
    expect_item("R5 ext div8", K_DELTA, c0, 10);
    // R5 rtc divide-by-8
    wr(mk(0, 1, 0, 6, 0));
    c0 = int'(cnt);
    run_rtc(48);
    cycles(8);
    expect_item("R5 rtc div8", K_DELTA, c0, 6);

    // R6 reserved code with every source active
    wr(mk(0, 1, 0, 7, 0));
    c0 = int'(cnt);
    fork
      run_ext(16);
      run_rtc(16);
      begin
        for (int i = 0; i < 4; i++) begin
          tmr0 = 1'b1; pin = 1'b0; cycles(4); tmr0 = 1'b0; pin = 1'b1; cycles(4);
        end
      end
    join
    cycles(8);
    expect_item("R6 reserved no ticks", K_DELTA, c0, 0);

    // R10 overflow on wrap
    @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    expect_item("R10 ovf cleared", K_OVF, 0, 0);
    wr(mk(0, 1, 0, 4, 0));
    c0 = int'(cnt);
    cycles((256 - c0) & CMASK);
    expect_item("R10 count wrapped", K_CNT, 0, 0);
    expect_item("R10 ovf set on wrap", K_OVF, 0, 1);
    expect_item("R11 irq masked", K_IRQ, 0, 0);
    wr(mk(0, 1, 0, 7, 1));
    expect_item("R11 irq raised", K_IRQ, 0, 1);
    cycles(5);
    expect_item("R10 ovf holds", K_OVF, 0, 1);
    @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    expect_item("R10 ovf cleared by input", K_OVF, 0, 0);
    expect_item("R11 irq drops", K_IRQ, 0, 0);

    // R9 lock behaviour
    wr(mk(0, 0, 0, 7, 0));
    expect_item("R9 wd clears unlocked", K_MODE, 0, 8'h38);
    wr(mk(0, 1, 1, 7, 0));
    expect_item("R9 wd and lock set", K_MODE, 0, 8'h3E);
    wr(mk(0, 0, 0, 0, 0));
    expect_item("R9 locked wd stays set", K_MODE, 0, 8'h06);
    wr(8'hFF);
    expect_item("R8 bit7 reads zero", K_MODE, 0, 8'h7F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule